// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps, for one processor, the record of which of 256 interrupt vectors are waiting and which are being serviced. Three 256-bit bitmaps hold that record: requests, in-service and trigger mode. A higher vector number always means a higher priority. Priority is judged on 4-bit classes, which are the upper nibble of a vector.

Sources post a vector with a level or edge flag. Software writes a 4-bit task priority and a 9-bit spurious register, whose top bit is the software enable. The processor sees a pending line. When it acknowledges, it gets back either the winning vector or the spurious vector. It ends handling with an end-of-interrupt strobe.

The processor priority is derived from the task priority and the top in-service vector, and it is driven out for observation. The pending line and the acknowledge vector are combinational from the registered state. All state changes on the rising clock edge.

Top module: `vprio_core`

## Requirements
- R1: Among the set bits of a bitmap, the highest-numbered one has the highest priority. A granted acknowledge always returns the highest set request vector.
- R2: A request sets the request bit of its vector. It also writes the vector's trigger bit: 1 for level, 0 for edge. On a granted acknowledge, `ack_level` shows the trigger bit of the returned vector.
- R3: `irq_pending` is low while bit 8 of the spurious register is 0, and also while no request bit is set.
- R4: When enabled with a request present, `irq_pending` is high in two cases. Either the processor priority is zero, or bits 7:4 of the top request are strictly greater than bits 7:4 of the processor priority.
- R5: `proc_prio` is chosen as follows. With no in-service bit set, it equals the task priority. Otherwise it equals the task priority when the task priority's class is at least the top in-service vector's class. In the remaining case it is that class followed by a zero low nibble.
- R6: An acknowledge is blocked when the task priority is nonzero and the top request is numerically less than or equal to it. A blocked acknowledge returns bits 7:0 of the spurious register and changes no bitmap.
- R7: A granted acknowledge returns the top request vector, clears its request bit, and sets its in-service bit, all on the same edge.
- R8: End-of-interrupt clears the highest set in-service bit. It has no effect when no in-service bit is set.
- R9: A task-priority write of a 4-bit value v stores v in bits 7:4, with bits 3:0 zero.
- R10: Reset sets the spurious register to 0x0FF, which leaves the block disabled. It also clears all three bitmaps and the task priority.
- R11: Events that fall in one cycle all act on the state from before that edge. A request wins over the clearing of an acknowledge for the same vector. An acknowledge's in-service set wins over an end-of-interrupt clear of the same bit.
- R12: An acknowledge while disabled, or with no request set, returns bits 7:0 of the spurious register and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset / init |
| req_valid | input | 1 | Post a request this cycle |
| req_vec | input | 8 | Vector of the posted request |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_wr | input | 1 | Write the task priority |
| tpr_val | input | 4 | Task-priority class to store |
| svr_wr | input | 1 | Write the spurious register |
| svr_val | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | Interrupt pending to the processor |
| ack_vec | output | 8 | Vector returned for an acknowledge this cycle |
| ack_level | output | 1 | Trigger bit of the returned vector on a granted acknowledge |
| proc_prio | output | 8 | Current processor priority |

## Verification
The delicate coincidence is a new request arriving in the same cycle as an acknowledge that takes the same vector. The request bit must end up set again. At the same time, the in-service bit must be set and the returned vector must be the old top request.

The bench provokes this on purpose by posting the acknowledged vector during the acknowledge. It then confirms, through a later acknowledge, that the vector is still requested. Random traffic also overlaps acknowledges with end-of-interrupt and requests, and every output is compared each cycle against a bench model that applies all events to the state from before the edge.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
    localparam int NVEC  = 256;
    localparam int VEC_W = $clog2(NVEC);
    localparam int CLS_W = 4;
    localparam int SVR_W = VEC_W + 1;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;
    typedef logic [NVEC-1:0]  map_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        logic level;
    } post_t;

    typedef struct packed {
        logic found;
        vec_t top;
    } pick_t;

    function automatic cls_t cls_of(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/vprio_find.sv
module vprio_find
    import vprio_pkg::*;
#(
    parameter int W  = NVEC,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/vprio_judge.sv
module vprio_judge
    import vprio_pkg::*;
(
    input  pick_t req_pick,
    input  pick_t svc_pick,
    input  vec_t  tpr,
    input  logic  sw_en,
    input  logic  ack,
    output vec_t  ppr,
    output logic  pending,
    output logic  grant
);
    logic blocked;

    always_comb begin
        if (svc_pick.found && (cls_of(tpr) < cls_of(svc_pick.top)))
            ppr = {cls_of(svc_pick.top), {(VEC_W-CLS_W){1'b0}}};
        else
            ppr = tpr;
    end

    assign pending = sw_en && req_pick.found &&
                     ((ppr == '0) || (cls_of(req_pick.top) > cls_of(ppr)));

    assign blocked = (tpr != '0) && (req_pick.top <= tpr);
    assign grant   = ack && sw_en && req_pick.found && !blocked;
endmodule

// File: rtl/vprio_core.sv
module vprio_core
    import vprio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             req_level,
    input  logic             tpr_wr,
    input  logic [CLS_W-1:0] tpr_val,
    input  logic             svr_wr,
    input  logic [SVR_W-1:0] svr_val,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_pending,
    output logic [VEC_W-1:0] ack_vec,
    output logic             ack_level,
    output logic [VEC_W-1:0] proc_prio
);
    map_t irr_q, isr_q, tmr_q;
    map_t irr_d, isr_d, tmr_d;
    vec_t tpr_q;
    logic [SVR_W-1:0] svr_q;
    pick_t req_pick, svc_pick;
    post_t post;
    logic grant;

    assign post = '{valid: req_valid, vec: req_vec, level: req_level};

    vprio_find #(.W(NVEC), .IW(VEC_W)) u_find_req (
        .bits(irr_q), .found(req_pick.found), .idx(req_pick.top));
    vprio_find #(.W(NVEC), .IW(VEC_W)) u_find_svc (
        .bits(isr_q), .found(svc_pick.found), .idx(svc_pick.top));

    vprio_judge u_judge (
        .req_pick(req_pick), .svc_pick(svc_pick), .tpr(tpr_q),
        .sw_en(svr_q[SVR_W-1]), .ack(ack),
        .ppr(proc_prio), .pending(irq_pending), .grant(grant));

    // every event acts on pre-edge state; later lines win on a shared bit
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (eoi && svc_pick.found) isr_d[svc_pick.top] = 1'b0;
        if (grant) begin
            irr_d[req_pick.top] = 1'b0;
            isr_d[req_pick.top] = 1'b1;
        end
        if (post.valid) begin
            irr_d[post.vec] = 1'b1;
            tmr_d[post.vec] = post.level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
            svr_q <= {1'b0, {VEC_W{1'b1}}};
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_wr) tpr_q <= {tpr_val, {(VEC_W-CLS_W){1'b0}}};
            if (svr_wr) svr_q <= svr_val;
        end
    end

    assign ack_vec   = grant ? req_pick.top : svr_q[VEC_W-1:0];
    assign ack_level = grant & tmr_q[req_pick.top];

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !svr_q[SVR_W-1] |-> !irq_pending); // R3
    AST_REQ_LANDS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> irr_q[$past(req_vec)]); // R2
    AST_GRANT_SERVICES: assert property (@(posedge clk) disable iff (rst)
        grant |=> isr_q[$past(req_pick.top)]); // R7
    AST_BLOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ack && !grant && !req_valid && !eoi) |=> ($stable(irr_q) && $stable(isr_q))); // R6
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && svc_pick.found && !grant) |=>
        ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R8
    AST_TPR_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        tpr_q[VEC_W-CLS_W-1:0] == '0); // R9
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        proc_prio >= tpr_q); // R5
endmodule

// File: tb/vprio_core_bench.sv
`timescale 1ns/1ps
module vprio_core_bench;
    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_level, tpr_wr, svr_wr, ack, eoi;
    logic [7:0] req_vec;
    logic [3:0] tpr_val;
    logic [8:0] svr_val;
    logic irq_pending, ack_level;
    logic [7:0] ack_vec, proc_prio;

    int checks = 0;
    int errors = 0;

    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic [8:0]   m_svr;

    always #2.5 clk = ~clk;

    vprio_core u_vprio_core (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
        .req_level(req_level), .tpr_wr(tpr_wr), .tpr_val(tpr_val),
        .svr_wr(svr_wr), .svr_val(svr_val), .ack(ack), .eoi(eoi),
        .irq_pending(irq_pending), .ack_vec(ack_vec), .ack_level(ack_level),
        .proc_prio(proc_prio));

    function automatic int hi(input logic [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    function automatic int e_ppr();
        int iv = hi(m_isr);
        if (iv < 0) return int'(m_tpr);
        if (int'(m_tpr[7:4]) >= (iv >> 4)) return int'(m_tpr);
        return (iv >> 4) << 4;
    endfunction

    function automatic bit e_pend();
        int rv = hi(m_irr);
        int pp = e_ppr();
        if (!m_svr[8] || rv < 0) return 1'b0;
        return (pp == 0) || ((rv >> 4) > (pp >> 4));
    endfunction

    function automatic bit e_grant();
        int rv = hi(m_irr);
        if (!ack || !m_svr[8] || rv < 0) return 1'b0;
        return !((m_tpr != 0) && (rv <= int'(m_tpr)));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; req_valid = 0; req_vec = 0; req_level = 0; tpr_wr = 0;
        tpr_val = 0; svr_wr = 0; svr_val = 0; ack = 0; eoi = 0;
    endtask

    // compare outputs mid-cycle, then step the model at the edge
    task automatic tick(input string tag);
        bit g;
        int rv, iv;
        #1;
        chk({tag, " pending"}, int'(irq_pending), int'(e_pend()));
        chk({tag, " proc_prio"}, int'(proc_prio), e_ppr());
        g  = e_grant();
        rv = hi(m_irr);
        iv = hi(m_isr);
        if (ack) begin
            chk({tag, " ack_vec"}, int'(ack_vec), g ? rv : int'(m_svr[7:0]));
            chk({tag, " ack_level"}, int'(ack_level), g ? int'(m_tmr[rv]) : 0);
        end
        @(posedge clk);
        if (rst) begin
            m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_svr = 9'h0FF;
        end else begin
            if (eoi && iv >= 0) m_isr[iv] = 1'b0;
            if (g) begin m_irr[rv] = 1'b0; m_isr[rv] = 1'b1; end
            if (req_valid) begin m_irr[req_vec] = 1'b1; m_tmr[req_vec] = req_level; end
            if (tpr_wr) m_tpr = {tpr_val, 4'h0};
            if (svr_wr) m_svr = svr_val;
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        m_irr = 'x; m_isr = 'x; m_tmr = 'x; m_tpr = 'x; m_svr = 'x;
        idle();
        @(negedge clk);
        rst = 1; tick("R10 reset");
        rst = 1; tick("R10 reset");
        chk("R10 reset spurious off", int'(irq_pending), 0);
        ack = 1; tick("R10 R12 disabled ack");
        svr_wr = 1; svr_val = 9'h13F; tick("R3 enable");
        req_valid = 1; req_vec = 8'h45; req_level = 0; tick("R2 edge post");
        req_valid = 1; req_vec = 8'h80; req_level = 1; tick("R4 pending");
        ack = 1; tick("R1 R7 top grant level");
        tick("R5 R4 masked by service");
        eoi = 1; tick("R8 eoi");
        eoi = 1; tick("R8 eoi empty");
        tpr_wr = 1; tpr_val = 4'h5; tick("R9 write");
        tick("R9 R4 class blocks");
        ack = 1; tick("R6 blocked ack");
        tpr_wr = 1; tpr_val = 4'h0; tick("R6 restore");
        ack = 1; tick("R6 state kept");
        req_valid = 1; req_vec = 8'h60; tick("R11 post");
        ack = 1; req_valid = 1; req_vec = 8'h60; req_level = 1; tick("R11 same vector");
        ack = 1; eoi = 1; tick("R11 ack with eoi");
        chk("R11 isr after overlap", int'(m_isr[8'h60]), 1);
        ack = 1; tick("R12 empty ack");
        req_valid = 1; req_vec = 8'h22; tick("R3 post");
        svr_wr = 1; svr_val = 9'h0AA; tick("R3 disable");
        ack = 1; tick("R12 disabled ack");
        for (int n = 0; n < 4000; n++) begin
            rst       = ($urandom_range(0, 199) == 0);
            req_valid = ($urandom_range(0, 1) == 1);
            req_vec   = 8'($urandom_range(0, 255));
            req_level = 1'($urandom_range(0, 1));
            tpr_wr    = ($urandom_range(0, 19) == 0);
            tpr_val   = 4'($urandom_range(0, 15));
            svr_wr    = ($urandom_range(0, 49) == 0);
            svr_val   = {($urandom_range(0, 4) != 0), 8'($urandom_range(0, 255))};
            ack       = ($urandom_range(0, 9) < 3);
            eoi       = ($urandom_range(0, 9) < 2);
            tick("R1 R4 R5 R7 R8 R11 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule